// File: doc/BRIEF.md
# SCSI Target Command Byte Collector

This block drives the command phase of a parallel SCSI target. After a start pulse it pulls a command descriptor block off the bus one byte at a time. For each byte it raises REQ and waits for the initiator's ACK. It then lets the data lines settle for a fixed time, samples them and drops REQ. It waits for ACK to fall before asking for the next byte. Each accepted byte is presented on an indexed strobe port, so a register file or buffer downstream can store it.

The total length of the command is not known in advance. The block works it out from the opcode byte, using the standard group lengths of 6, 10, 12 or 16 bytes. Some host adapters put a 0x1F escape byte in front of the opcode. When the very first byte is 0x1F, the block discards it and fetches the real opcode with one more handshake.

Every wait on ACK is limited by a timeout, and every wait also watches the bus reset line. When either one trips, the block stops, pulses done and reports how many bytes finished a full handshake. Time limits are given in nanoseconds and microseconds and converted to clock cycles from a clock-frequency parameter. ACK and RST pass through a synchronizer of configurable depth.

Top module: `cdb_capture`

## Requirements
- R1: After reset, req_o, done_o and byte_vld_o are 0 and rx_count_o is 0. A start_i pulse while a collection is running has no effect on the bytes or count produced.
- R2: req_o rises to request each byte. Once ACK is seen high, req_o stays high for at least the settle time (400 ns by default) before it falls. While ACK is still high after a byte, req_o does not rise again.
- R3: Each kept byte gives a one-cycle byte_vld_o, with byte_data_o equal to the sampled bus value. byte_idx_o counts 0, 1, 2… in the order the bytes are received.
- R4: Opcodes 0x88, 0x8A, 0x8F, 0x91, 0x9E and 0x9F set a command length of 16 bytes.
- R5: Opcode 0xA0 sets a command length of 12 bytes.
- R6: Opcode 0x05, and every opcode from 0x20 to 0x7D inclusive, set a command length of 10 bytes.
- R7: Every other opcode sets a command length of 6 bytes. This includes 0x7E and 0x04.
- R8: A 0x1F in the first handshake is dropped, with no strobe, and the byte that follows is strobed as index 0 and decoded as the opcode. A 0x1F that arrives as that opcode is kept and gives 6 bytes.
- R9: When the last byte's ACK falls, done_o pulses for exactly one cycle, rx_count_o equals the command length, and rx_count_o holds until the next start.
- R10: If ACK does not rise within the timeout, the block aborts: req_o goes low, done_o pulses and rx_count_o equals the number of fully completed bytes. That number is 0 for the first byte or for the opcode after a prefix.
- R11: If ACK does not fall within the timeout after a byte was sampled, the block aborts. That byte has been strobed but is not counted in rx_count_o.
- R12: RST seen high during any wait for ACK aborts the collection within a few cycles (synchronizer depth plus two), with done_o pulsed and the count of completed bytes reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin collecting a command |
| scsi_ack_i | input | 1 | ACK from initiator, active high, asynchronous |
| scsi_rst_i | input | 1 | Bus reset, active high, asynchronous |
| scsi_data_i | input | 8 | Data bus value |
| scsi_req_o | output | 1 | REQ to initiator, active high |
| byte_vld_o | output | 1 | One-cycle strobe for a kept byte |
| byte_idx_o | output | 4 | Position of the strobed byte in the command |
| byte_data_o | output | 8 | Value of the strobed byte |
| done_o | output | 1 | One-cycle pulse at completion or abort |
| rx_count_o | output | 5 | Completed byte count, valid after done_o until next start |

## Verification
The bench hits the length boundaries: 0x04, 0x05, 0x1F, 0x20, 0x7D, 0x7E, 0x9F and 0xA0. A decoder with an off-by-one range would stop a byte early or hang waiting for a 17th REQ. It sends a double 0x1F to catch a design that strips every prefix instead of only the first one, which would leave index 0 holding the wrong byte. Timeouts and bus resets are injected both before ACK rises and while ACK is held high. A design that counts the sampled-but-unreleased byte, or that re-raises REQ under a held ACK, reports a wrong count or makes a stray request. REQ hold time is also measured against the settle time.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

  typedef enum logic [1:0] {
    CS_IDLE   = 2'd0,
    CS_REQ    = 2'd1,
    CS_SETTLE = 2'd2,
    CS_REL    = 2'd3
  } cdb_state_e;

  localparam int LEN_W = 5;
  localparam int IDX_W = 4;
  localparam logic [7:0] PREFIX_BYTE = 8'h1F;

endpackage

// File: rtl/cdb_sync.sv
module cdb_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
          stage_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/cdb_len_decode.sv
module cdb_len_decode
  import cdb_pkg::*;
(
  input  logic [7:0]       opcode_i,
  output logic [LEN_W-1:0] len_o
);
  always_comb begin
    unique case (opcode_i)
      8'h88, 8'h8A, 8'h8F, 8'h91, 8'h9E, 8'h9F: len_o = LEN_W'(16);
      8'hA0:                                     len_o = LEN_W'(12);
      default: begin
        if (opcode_i == 8'h05 || (opcode_i >= 8'h20 && opcode_i <= 8'h7D))
          len_o = LEN_W'(10);
        else
          len_o = LEN_W'(6);
      end
    endcase
  end

  // R4 R5 R6 R7: only the four legal group lengths leave the decoder
  always_comb begin
    a_r4_len_legal: assert (len_o == 5'd6 || len_o == 5'd10 || len_o == 5'd12 || len_o == 5'd16);
  end
endmodule

// File: rtl/cdb_wait_timer.sv
module cdb_wait_timer #(
  parameter int SETTLE_CYC = 50,
  parameter int TMO_CYC    = 375_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic settle_hit_o,
  output logic tmo_hit_o
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam logic [TW-1:0] SETTLE_LAST = TW'(SETTLE_CYC - 1);
  localparam logic [TW-1:0] TMO_LAST    = TW'(TMO_CYC - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = clr_i || (cnt_q != TMO_LAST);

  always_comb begin
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign settle_hit_o = (cnt_q >= SETTLE_LAST);
  assign tmo_hit_o    = (cnt_q == TMO_LAST);

  // R10: the counter never runs past its last value
  a_r10_tmr_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TMO_LAST);
endmodule

// File: rtl/cdb_hs_ctrl.sv
module cdb_hs_ctrl
  import cdb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ack_s_i,
  input  logic             brst_s_i,
  input  logic [7:0]       data_i,
  input  logic [LEN_W-1:0] dec_len_i,
  input  logic             settle_hit_i,
  input  logic             tmo_hit_i,
  output logic             tmr_clr_o,
  output logic             req_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_data_o,
  output logic             done_o,
  output logic [LEN_W-1:0] count_o
);
  cdb_state_e       st_q, st_d;
  logic             req_q, req_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             first_q, first_d;
  logic             pre_q, pre_d;
  logic             vld_q, vld_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [7:0]       dat_q, dat_d;
  logic             done_q, done_d;
  logic [LEN_W-1:0] cnt_inc;
  logic             is_prefix;

  assign cnt_inc   = cnt_q + LEN_W'(1);
  assign is_prefix = first_q && (data_i == PREFIX_BYTE);

  always_comb begin
    st_d    = st_q;
    req_d   = req_q;
    cnt_d   = cnt_q;
    len_d   = len_q;
    first_d = first_q;
    pre_d   = pre_q;
    vld_d   = 1'b0;
    idx_d   = idx_q;
    dat_d   = dat_q;
    done_d  = 1'b0;
    unique case (st_q)
      CS_IDLE: begin
        if (start_i) begin
          st_d    = CS_REQ;
          req_d   = 1'b1;
          cnt_d   = '0;
          first_d = 1'b1;
          pre_d   = 1'b0;
        end
      end
      CS_REQ: begin
        if (brst_s_i || (!ack_s_i && tmo_hit_i)) begin
          st_d   = CS_IDLE;
          req_d  = 1'b0;
          done_d = 1'b1;
        end else if (ack_s_i) begin
          st_d = CS_SETTLE;
        end
      end
      CS_SETTLE: begin
        if (settle_hit_i) begin
          st_d    = CS_REL;
          req_d   = 1'b0;
          first_d = 1'b0;
          pre_d   = is_prefix;
          if (!is_prefix) begin
            vld_d = 1'b1;
            idx_d = cnt_q[IDX_W-1:0];
            dat_d = data_i;
            if (cnt_q == '0) len_d = dec_len_i;
          end
        end
      end
      CS_REL: begin
        if (brst_s_i || (ack_s_i && tmo_hit_i)) begin
          st_d   = CS_IDLE;
          done_d = 1'b1;
        end else if (!ack_s_i) begin
          if (pre_q) begin
            st_d  = CS_REQ;
            req_d = 1'b1;
          end else if (cnt_inc == len_q) begin
            st_d   = CS_IDLE;
            cnt_d  = cnt_inc;
            done_d = 1'b1;
          end else begin
            st_d  = CS_REQ;
            req_d = 1'b1;
            cnt_d = cnt_inc;
          end
        end
      end
      default: st_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= CS_IDLE;
      req_q   <= 1'b0;
      cnt_q   <= '0;
      len_q   <= LEN_W'(6);
      first_q <= 1'b0;
      pre_q   <= 1'b0;
      vld_q   <= 1'b0;
      idx_q   <= '0;
      dat_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      req_q   <= req_d;
      cnt_q   <= cnt_d;
      len_q   <= len_d;
      first_q <= first_d;
      pre_q   <= pre_d;
      vld_q   <= vld_d;
      idx_q   <= idx_d;
      dat_q   <= dat_d;
      done_q  <= done_d;
    end
  end

  assign tmr_clr_o   = (st_d != st_q);
  assign req_o       = req_q;
  assign byte_vld_o  = vld_q;
  assign byte_idx_o  = idx_q;
  assign byte_data_o = dat_q;
  assign done_o      = done_q;
  assign count_o     = cnt_q;

  // R1: no request is outstanding while idle
  a_r1_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_IDLE) |-> !req_q);
  // R2: REQ is already dropped when a byte is presented
  a_r2_req_low_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> !req_q);
  // R3: later byte indices stay inside the decoded length
  a_r3_idx_in_len: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && idx_q != '0) |-> ({1'b0, idx_q} < len_q));
  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R9: count holds while idle without a start
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == CS_IDLE && !start_i) |=> $stable(cnt_q));
  // R12: bus reset during a wait ends the collection next cycle
  a_r12_rst_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (brst_s_i && (st_q == CS_REQ || st_q == CS_REL)) |=> (done_q && !req_q));
  // R9: the count never exceeds the longest command
  a_r9_count_max: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LEN_W'(16));
endmodule

// File: rtl/cdb_capture.sv
module cdb_capture
  import cdb_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int SETTLE_NS   = 400,
  parameter int TIMEOUT_US  = 3_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             scsi_ack_i,
  input  logic             scsi_rst_i,
  input  logic [7:0]       scsi_data_i,
  output logic             scsi_req_o,
  output logic             byte_vld_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [7:0]       byte_data_o,
  output logic             done_o,
  output logic [LEN_W-1:0] rx_count_o
);
  localparam longint SETTLE_L = (longint'(CLK_HZ) * longint'(SETTLE_NS)
                                 + longint'(999_999_999)) / longint'(1_000_000_000);
  localparam longint TMO_L    = (longint'(CLK_HZ) / longint'(1_000_000)) * longint'(TIMEOUT_US);
  localparam int SETTLE_CYC   = (SETTLE_L < 1) ? 1 : int'(SETTLE_L);
  localparam int TMO_CYC      = (TMO_L <= SETTLE_L) ? SETTLE_CYC + 1 : int'(TMO_L);

  logic       rst_meta_q, rst_sync_n;
  logic [1:0] bus_s;
  logic [LEN_W-1:0] dec_len;
  logic       tmr_clr, settle_hit, tmo_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cdb_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({scsi_rst_i, scsi_ack_i}),
    .q_o   (bus_s)
  );

  cdb_len_decode u_dec (
    .opcode_i (scsi_data_i),
    .len_o    (dec_len)
  );

  cdb_wait_timer #(.SETTLE_CYC(SETTLE_CYC), .TMO_CYC(TMO_CYC)) u_tmr (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .clr_i        (tmr_clr),
    .settle_hit_o (settle_hit),
    .tmo_hit_o    (tmo_hit)
  );

  cdb_hs_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .start_i      (start_i),
    .ack_s_i      (bus_s[0]),
    .brst_s_i     (bus_s[1]),
    .data_i       (scsi_data_i),
    .dec_len_i    (dec_len),
    .settle_hit_i (settle_hit),
    .tmo_hit_i    (tmo_hit),
    .tmr_clr_o    (tmr_clr),
    .req_o        (scsi_req_o),
    .byte_vld_o   (byte_vld_o),
    .byte_idx_o   (byte_idx_o),
    .byte_data_o  (byte_data_o),
    .done_o       (done_o),
    .count_o      (rx_count_o)
  );
endmodule

// File: tb/tb_cdb_capture.sv
`timescale 1ns/1ps
module tb_cdb_capture;
  localparam int SETTLE_MIN = 50;   // 400 ns at 125 MHz
  localparam int TMO_CYC    = 250;  // 2 us at 125 MHz

  logic clk, rst_n, start_i, ack, brst;
  logic [7:0] data;
  logic req, vld, done;
  logic [3:0] idx;
  logic [7:0] bdat;
  logic [4:0] cnt;

  int n_chk, n_bad;
  int exp_q[$];
  bit done_seen, prev_done;
  logic [7:0] cb [0:19];

  cdb_capture #(.CLK_HZ(125_000_000), .SETTLE_NS(400), .TIMEOUT_US(2), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scsi_ack_i(ack), .scsi_rst_i(brst),
    .scsi_data_i(data), .scsi_req_o(req), .byte_vld_o(vld), .byte_idx_o(idx),
    .byte_data_o(bdat), .done_o(done), .rx_count_o(cnt));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [7:0] op);
    if (op == 8'hA0) return 12;
    if (op == 8'h88 || op == 8'h8A || op == 8'h8F || op == 8'h91 || op == 8'h9E || op == 8'h9F) return 16;
    if (op == 8'h05 || (op >= 8'h20 && op <= 8'h7D)) return 10;
    return 6;
  endfunction

  // monitor: scoreboard pop and done pulse width (R3, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (vld) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected strobe", {idx, bdat}, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk({idx, bdat} == e[11:0], "R3 strobe idx/data", {idx, bdat}, e);
        end
      end
      if (done) begin
        chk(!prev_done, "R9 done width", 2, 1);
        done_seen = 1'b1;
      end
      prev_done = done;
    end
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  // kind: 0 normal, 1 no ACK, 2 ACK held, 3 RST before ACK, 4 RST while ACK held
  task automatic run_cmd(input int n, input int stop_h, input int kind,
                         input int exp_cnt, input bit poke, input string tag);
    int last, k, h, el;
    last = (kind == 1 || kind == 3) ? stop_h - 1 : (kind == 0 ? n - 1 : stop_h);
    k = 0;
    for (int i = 0; i <= last; i++) begin
      if (!(i == 0 && cb[0] == 8'h1F)) begin
        exp_q.push_back((k << 8) | cb[i]);
        k++;
      end
    end
    done_seen = 1'b0;
    start_i = 1'b1; step(); start_i = 1'b0;
    h = 0;
    forever begin
      while (!req && !done_seen) step();
      if (done_seen) break;
      if (h == stop_h && kind == 1) begin
        while (!done_seen) step();
        break;
      end
      if (h == stop_h && kind == 3) begin
        brst = 1'b1; el = 0;
        while (!done_seen) begin step(); el++; end
        chk(el <= 5, {"R12 rst latency ", tag}, el, 5);
        brst = 1'b0;
        break;
      end
      data = cb[h]; ack = 1'b1; el = 0;
      while (req) begin step(); el++; end
      chk(el >= SETTLE_MIN, {"R2 settle hold ", tag}, el, SETTLE_MIN);
      if (h == stop_h && kind == 2) begin
        while (!done_seen) begin
          step();
          chk(!req, {"R2 req under held ack ", tag}, req, 0);
        end
        ack = 1'b0;
        break;
      end
      if (h == stop_h && kind == 4) begin
        brst = 1'b1;
        while (!done_seen) step();
        brst = 1'b0; ack = 1'b0;
        break;
      end
      if (poke && h == 1) begin
        start_i = 1'b1; step(); start_i = 1'b0;   // R1: ignored while busy
      end
      repeat (3) step();
      ack = 1'b0;
      h++;
    end
    step();
    chk(cnt == exp_cnt, {"R9 R10 count ", tag}, cnt, exp_cnt);
    chk(!req, {"R10 req low after end ", tag}, req, 0);
    chk(exp_q.size() == 0, {"R3 missing strobes ", tag}, exp_q.size(), 0);
    exp_q.delete();
    done_seen = 1'b0;
    repeat (20) step();
    chk(cnt == exp_cnt && !done_seen && !req, {"R9 count hold ", tag}, cnt, exp_cnt);
  endtask

  task automatic load1(input logic [7:0] op);
    cb[0] = op;
    for (int i = 1; i < 20; i++) cb[i] = 8'(8'hB0 + i);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; prev_done = 0; done_seen = 0;
    start_i = 0; ack = 0; brst = 0; data = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) step();
    chk(!req && !done && !vld && cnt == 0, "R1 reset state", {req, done, vld, cnt}, 0);

    load1(8'h12); run_cmd(6, -1, 0, 6, 0, "op12 R7");
    load1(8'h04); run_cmd(6, -1, 0, 6, 0, "op04 R7");
    load1(8'h7E); run_cmd(6, -1, 0, 6, 0, "op7E R7");
    load1(8'h05); run_cmd(10, -1, 0, 10, 0, "op05 R6");
    load1(8'h20); run_cmd(10, -1, 0, 10, 0, "op20 R6");
    load1(8'h7D); run_cmd(10, -1, 0, exp_len(8'h7D), 1, "op7D R6 R1");
    load1(8'hA0); run_cmd(12, -1, 0, exp_len(8'hA0), 0, "opA0 R5");
    load1(8'h9F); run_cmd(16, -1, 0, 16, 0, "op9F R4");
    load1(8'h1F); cb[1] = 8'h88; run_cmd(17, -1, 0, 16, 0, "prefix 88 R8 R4");
    load1(8'h1F); cb[1] = 8'h1F; run_cmd(7, -1, 0, 6, 0, "double 1F R8");
    load1(8'h28); run_cmd(10, 3, 1, 3, 0, "ack timeout R10");
    load1(8'h28); run_cmd(10, 0, 1, 0, 0, "first timeout R10");
    load1(8'h1F); cb[1] = 8'h28; run_cmd(11, 1, 1, 0, 0, "prefix timeout R10");
    load1(8'h28); run_cmd(10, 4, 2, 4, 0, "release timeout R11");
    load1(8'h28); run_cmd(10, 2, 3, 2, 0, "rst wait R12");
    load1(8'hA0); run_cmd(12, 5, 4, 5, 0, "rst release R12");
    load1(8'h1F); cb[1] = 8'h12; run_cmd(7, 1, 3, 0, 0, "rst after prefix R12");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule